// File: doc/BRIEF.md
# Per-Lane Eye-Scan Self-Test Engine

This block measures the usable sampling window of every receive lane in a group that shares one forwarded clock. Once started, it steps a delay code, sent to the test samplers, from 0 up to the last step. Each step is held for a programmable dwell of 2^k bit times. On every bit time it compares each lane's sampled bit against the expected data. A step passes on a lane only if no bit in the whole dwell mismatched. Each result is stored in a per-lane pass map with one bit per delay step. The maps of all lanes together give a picture of each lane's eye opening.

The expected data is the reference bit stream. When scrambling is enabled, that stream is XORed with a 23-bit pseudo-random sequence (x^23 + x^18 + 1). When scrambling is disabled, the plain reference bits are used. An adjacent-lane inversion mode flips the expected data on every odd-numbered lane. This lets eye widths measured with alternately inverted traffic be compared with normal traffic, which exposes crosstalk and return-path sensitivity.

Any lane's map can be read at any time through a lane-select read port, including while a sweep is in progress. The current delay code is always visible on its own output.

Top module: `eyescan_bist`

## Requirements
- R1: After reset, busy_o, done_o and step_valid_o are 0, and every lane map reads back as all zeros.
- R2: A start_i pulse while idle clears every lane map and raises busy_o on the next cycle, with sample_code_o at 0. It also reseeds the sequence generator and latches dwell_log_i, scramble_en_i and alt_inv_i for the whole sweep.
- R3: sample_code_o stays constant for exactly 2^k cycles (k = latched dwell_log_i) and then increments by one. The sweep therefore lasts STEPS × 2^k cycles.
- R4: Bit s of a lane's map is 1 only if all 2^k compared bits of that lane at code s matched the expected bit. A single mismatch anywhere in the dwell, including the last bit, makes it 0.
- R5: With scrambling on, the expected base bit is ref_bit_i XOR the generator output. The generator holds 23 bits and is seeded to all ones, so its first output bit is 1. Its output is state bit 22, and it shifts left each busy cycle, inserting bit22 XOR bit17.
- R6: With scrambling off, the expected base bit is ref_bit_i alone.
- R7: With inversion on, lanes with an odd index expect the inverted base bit, and lanes with an even index expect the base bit.
- R8: One cycle after the last compare of the final step, busy_o falls and done_o rises. done_o stays high until the next accepted start.
- R9: A start_i pulse while busy_o is high has no effect: the code sequence, the maps and the compare stream continue unchanged.
- R10: rd_map_o always shows the map of lane rd_lane_i, combinationally. During a sweep, it already holds the results of every completed step.
- R11: One cycle after the last compare of each step, step_valid_o pulses for one cycle. At the same time, step_pass_o carries that step's pass bit for every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Sweep start request |
| dwell_log_i | input | DL_W | Dwell exponent k (clamped to MAX_DWELL_LOG) |
| scramble_en_i | input | 1 | Use the scrambled expected data |
| alt_inv_i | input | 1 | Invert the expected data on odd lanes |
| ref_bit_i | input | 1 | Unscrambled reference bit for this cycle |
| rx_lane_i | input | LANES | Test-sampler output bit of each lane |
| rd_lane_i | input | LANE_W | Lane selected for map readout |
| sample_code_o | output | CODE_W | Delay code sent to the test samplers |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Last sweep completed |
| step_valid_o | output | 1 | Step result strobe |
| step_pass_o | output | LANES | Per-lane result of the step just closed |
| rd_map_o | output | STEPS | Pass map of the selected lane |

## Verification
If the sequence generator falls out of step with the transmitter, most fail bits appear on every lane at the very first step_valid_o strobe. That result is visible after a single dwell. If the dwell counter has the wrong mask, sample_code_o moves on the wrong cycle at the first step boundary, and the total sweep length no longer equals STEPS × 2^k. If a lane's error flag gets stuck or is not cleared between steps, the window edges of rd_map_o shift. In that case the next step_pass_o strobe after an injected single-bit error differs from the expected one. The bench therefore checks the code on every cycle, the strobe at every step, and the full maps bit by bit. It places single errors at a different dwell offset on each step.

// File: rtl/eyescan_pkg.sv
`timescale 1ns/1ps
package eyescan_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE  = 1'b0,
      SEQ_SWEEP = 1'b1
   } seq_state_e;

   // Second feedback tap (1-based) of a maximal-length two-tap sequence
   function automatic int prbs_tap(input int order);
      case (order)
         7:       return 6;
         15:      return 14;
         23:      return 18;
         31:      return 28;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/eyescan_prbs.sv
`timescale 1ns/1ps
module eyescan_prbs #(
   parameter int ORDER = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic adv_i,
   output logic bit_o
);
   import eyescan_pkg::*;

   localparam int TAP = prbs_tap(ORDER);

   if (TAP == 0) begin : g_bad_order
      $error("eyescan_prbs: unsupported ORDER %0d", ORDER);
   end

   logic [ORDER-1:0] state_q;
   logic             fb;

   assign fb    = state_q[ORDER-1] ^ state_q[TAP-1];
   assign bit_o = state_q[ORDER-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '1;
      end else if (load_i) begin
         state_q <= '1;
      end else if (adv_i) begin
         state_q <= {state_q[ORDER-2:0], fb};
      end
   end

   AST_SEED_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> bit_o); // R5

endmodule

// File: rtl/eyescan_seq.sv
`timescale 1ns/1ps
module eyescan_seq #(
   parameter int STEPS         = 64,
   parameter int MAX_DWELL_LOG = 12,
   parameter int CODE_W        = $clog2(STEPS),
   parameter int DL_W          = $clog2(MAX_DWELL_LOG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DL_W-1:0]   dwell_log_i,
   output logic              busy_o,
   output logic              start_acc_o,
   output logic              last_o,
   output logic              final_o,
   output logic [CODE_W-1:0] code_o,
   output logic              done_o,
   output logic              valid_o
);
   import eyescan_pkg::*;

   localparam int DCNT_W = MAX_DWELL_LOG;
   localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(STEPS - 1);

   if (MAX_DWELL_LOG < 1) begin : g_bad_dwell
      $error("eyescan_seq: MAX_DWELL_LOG must be at least 1");
   end

   seq_state_e          st_q;
   logic [DCNT_W-1:0]   cnt_q;
   logic [DCNT_W-1:0]   mask_q;
   logic [DCNT_W-1:0]   mask_d;
   logic [DCNT_W:0]     span;
   logic [DL_W-1:0]     k_eff;
   logic [CODE_W-1:0]   code_q;
   logic                done_q;
   logic                valid_q;

   always_comb begin
      if (dwell_log_i > DL_W'(MAX_DWELL_LOG)) k_eff = DL_W'(MAX_DWELL_LOG);
      else                                    k_eff = dwell_log_i;
      span   = ({{DCNT_W{1'b0}}, 1'b1} << k_eff) - 1'b1;
      mask_d = span[DCNT_W-1:0];
   end

   assign busy_o      = (st_q == SEQ_SWEEP);
   assign start_acc_o = start_i && !busy_o;
   assign last_o      = busy_o && (cnt_q == mask_q);
   assign final_o     = last_o && (code_q == LAST_CODE);
   assign code_o      = code_q;
   assign done_o      = done_q;
   assign valid_o     = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         cnt_q   <= '0;
         mask_q  <= '0;
         code_q  <= '0;
         done_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= last_o;
         if (start_acc_o) begin
            st_q   <= SEQ_SWEEP;
            cnt_q  <= '0;
            code_q <= '0;
            mask_q <= mask_d;
            done_q <= 1'b0;
         end else if (last_o) begin
            cnt_q <= '0;
            if (final_o) begin
               st_q   <= SEQ_IDLE;
               done_q <= 1'b1;
            end else begin
               code_q <= code_q + 1'b1;
            end
         end else if (busy_o) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o |=> $stable(code_o)); // R3
   AST_CODE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !final_o |=> code_o == $past(code_o) + 1'b1); // R3
   AST_FINAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      final_o |=> done_o && !busy_o); // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !last_o |=> busy_o && $stable(code_o)); // R9
   AST_STEP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> valid_o); // R11
   AST_START_CODE0: assert property (@(posedge clk) disable iff (!rst_n)
      start_acc_o |=> busy_o && code_o == '0); // R2

endmodule

// File: rtl/eyescan_lane.sv
`timescale 1ns/1ps
module eyescan_lane #(
   parameter int STEPS  = 64,
   parameter int CODE_W = $clog2(STEPS),
   parameter bit ODD    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              busy_i,
   input  logic              last_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              base_i,
   input  logic              alt_i,
   input  logic              rx_i,
   output logic              pass_o,
   output logic [STEPS-1:0]  map_o
);
   logic             exp_bit;
   logic             miss;
   logic             err_q;
   logic             pass_q;
   logic             step_ok;
   logic [STEPS-1:0] map_q;

   if (ODD) begin : g_odd
      assign exp_bit = base_i ^ alt_i;
   end else begin : g_even
      assign exp_bit = base_i;
   end

   assign miss    = busy_i && (rx_i != exp_bit);
   assign step_ok = !(err_q || miss);
   assign pass_o  = pass_q;
   assign map_o   = map_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         pass_q <= 1'b0;
         map_q  <= '0;
      end else if (clear_i) begin
         err_q  <= 1'b0;
         pass_q <= 1'b0;
         map_q  <= '0;
      end else if (last_i) begin
         err_q         <= 1'b0;
         pass_q        <= step_ok;
         map_q[code_i] <= step_ok;
      end else if (miss) begin
         err_q <= 1'b1;
      end
   end

   AST_MAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> map_o == '0); // R2
   AST_MISS_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      last_i && (rx_i != exp_bit) |=> !pass_o); // R4
   AST_MAP_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
      last_i |=> map_o[$past(code_i)] == pass_o); // R4

endmodule

// File: rtl/eyescan_bist.sv
`timescale 1ns/1ps
module eyescan_bist #(
   parameter int LANES         = 16,
   parameter int STEPS         = 64,
   parameter int MAX_DWELL_LOG = 12,
   parameter int PRBS_ORDER    = 23,
   parameter bit HAS_SCRAMBLER = 1'b1,
   parameter int CODE_W        = $clog2(STEPS),
   parameter int LANE_W        = (LANES > 1) ? $clog2(LANES) : 1,
   parameter int DL_W          = $clog2(MAX_DWELL_LOG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [DL_W-1:0]   dwell_log_i,
   input  logic              scramble_en_i,
   input  logic              alt_inv_i,
   input  logic              ref_bit_i,
   input  logic [LANES-1:0]  rx_lane_i,
   input  logic [LANE_W-1:0] rd_lane_i,
   output logic [CODE_W-1:0] sample_code_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              step_valid_o,
   output logic [LANES-1:0]  step_pass_o,
   output logic [STEPS-1:0]  rd_map_o
);
   if (STEPS < 2 || (1 << CODE_W) < STEPS) begin : g_bad_steps
      $error("eyescan_bist: STEPS %0d does not fit CODE_W", STEPS);
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("eyescan_bist: LANES must be positive");
   end

   logic              start_acc;
   logic              last_cyc;
   logic              final_cyc;
   logic              scr_q;
   logic              alt_q;
   logic              base_bit;
   logic [STEPS-1:0]  maps [LANES];

   eyescan_seq #(
      .STEPS         (STEPS),
      .MAX_DWELL_LOG (MAX_DWELL_LOG),
      .CODE_W        (CODE_W),
      .DL_W          (DL_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .dwell_log_i (dwell_log_i),
      .busy_o      (busy_o),
      .start_acc_o (start_acc),
      .last_o      (last_cyc),
      .final_o     (final_cyc),
      .code_o      (sample_code_o),
      .done_o      (done_o),
      .valid_o     (step_valid_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scr_q <= 1'b0;
         alt_q <= 1'b0;
      end else if (start_acc) begin
         scr_q <= scramble_en_i;
         alt_q <= alt_inv_i;
      end
   end

   if (HAS_SCRAMBLER) begin : g_scr
      logic prbs_bit;
      eyescan_prbs #(.ORDER(PRBS_ORDER)) u_prbs (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (start_acc),
         .adv_i  (busy_o),
         .bit_o  (prbs_bit)
      );
      assign base_bit = scr_q ? (ref_bit_i ^ prbs_bit) : ref_bit_i;
   end else begin : g_plain
      assign base_bit = ref_bit_i;
   end

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      eyescan_lane #(
         .STEPS  (STEPS),
         .CODE_W (CODE_W),
         .ODD    ((gi % 2) == 1)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (start_acc),
         .busy_i  (busy_o),
         .last_i  (last_cyc),
         .code_i  (sample_code_o),
         .base_i  (base_bit),
         .alt_i   (alt_q),
         .rx_i    (rx_lane_i[gi]),
         .pass_o  (step_pass_o[gi]),
         .map_o   (maps[gi])
      );
   end

   always_comb begin
      rd_map_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (rd_lane_i == LANE_W'(i)) rd_map_o = maps[i];
      end
   end

   AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      final_cyc |=> !busy_o && step_valid_o); // R8
   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> !busy_o && !step_valid_o); // R11

endmodule

// File: tb/eyescan_bist_bench.sv
`timescale 1ns/1ps
module eyescan_bist_bench;
   localparam int NL = 16;
   localparam int NS = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [3:0]    dwell_log_i = '0;
   logic          scramble_en_i = 1'b0;
   logic          alt_inv_i = 1'b0;
   logic          ref_bit_i = 1'b0;
   logic [NL-1:0] rx_lane_i = '0;
   logic [3:0]    rd_lane_i = '0;
   logic [5:0]    sample_code_o;
   logic          busy_o;
   logic          done_o;
   logic          step_valid_o;
   logic [NL-1:0] step_pass_o;
   logic [NS-1:0] rd_map_o;

   int nvec = 0;
   int nbad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   eyescan_bist u_eyescan_bist (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .dwell_log_i   (dwell_log_i),
      .scramble_en_i (scramble_en_i),
      .alt_inv_i     (alt_inv_i),
      .ref_bit_i     (ref_bit_i),
      .rx_lane_i     (rx_lane_i),
      .rd_lane_i     (rd_lane_i),
      .sample_code_o (sample_code_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .step_valid_o  (step_valid_o),
      .step_pass_o   (step_pass_o),
      .rd_map_o      (rd_map_o)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit in_window(input int lane, input int s);
      int lo = (lane * 3) % 20;
      return (s >= lo) && (s <= lo + 18 + lane);
   endfunction

   function automatic bit exp_pass(input int lane, input int s,
                                   input bit alt_dut, input bit alt_tx);
      bit skewed = (alt_dut != alt_tx) && (lane % 2 == 1);
      return in_window(lane, s) && !skewed;
   endfunction

   function automatic logic [NL-1:0] exp_vec(input int s, input bit alt_dut,
                                             input bit alt_tx);
      logic [NL-1:0] v;
      for (int i = 0; i < NL; i++) v[i] = exp_pass(i, s, alt_dut, alt_tx);
      return v;
   endfunction

   task automatic sweep(input int k, input bit scr, input bit alt_dut,
                        input bit alt_tx, input int ign_n, input string tag);
      logic [22:0]   lf;
      logic [NS-1:0] want;
      int            n;
      int            dw;
      int            s;
      int            off;
      bit            refb;
      bit            base;
      dw            = 1 << k;
      dwell_log_i   = 4'(k);
      scramble_en_i = scr;
      alt_inv_i     = alt_dut;
      rd_lane_i     = 4'd3;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1 && done_o == 1'b0, "R2 busy after start", 64'(busy_o), 64'd1);
      chk(rd_map_o == '0, "R2 map cleared", rd_map_o, 64'd0);
      lf = '1;
      n  = 0;
      while (busy_o && n < NS * dw + 4) begin
         s   = n / dw;
         off = n % dw;
         chk(sample_code_o == 6'(s), "R3 code", 64'(sample_code_o), 64'(s));
         if (off == 0 && n > 0) begin
            chk(step_valid_o && step_pass_o == exp_vec(s - 1, alt_dut, alt_tx),
                "R11 step strobe", 64'(step_pass_o), 64'(exp_vec(s - 1, alt_dut, alt_tx)));
         end else begin
            chk(!step_valid_o, "R11 no strobe", 64'(step_valid_o), 64'd0);
         end
         if (s == 40 && off == 0) begin
            want = '0;
            for (int j = 0; j < 40; j++) want[j] = exp_pass(3, j, alt_dut, alt_tx);
            chk(rd_map_o[39:0] == want[39:0], "R10 live readout",
                64'(rd_map_o[39:0]), 64'(want[39:0]));
         end
         start_i   = (n == ign_n);
         refb      = 1'(((n * 7) >> 2) & 1);
         base      = scr ? (refb ^ lf[22]) : refb;
         ref_bit_i = refb;
         for (int i = 0; i < NL; i++) begin
            rx_lane_i[i] = base ^ (alt_tx && (i % 2 == 1))
                           ^ (!in_window(i, s) && off == (s % dw));
         end
         lf = {lf[21:0], lf[22] ^ lf[17]};
         n++;
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(n == NS * dw, "R3 sweep length", 64'(n), 64'(NS * dw));
      chk(done_o && !busy_o, "R8 done after last step", {62'd0, done_o, busy_o}, 64'd2);
      chk(step_valid_o && step_pass_o == exp_vec(NS - 1, alt_dut, alt_tx),
          "R11 final strobe", 64'(step_pass_o), 64'(exp_vec(NS - 1, alt_dut, alt_tx)));
      for (int i = 0; i < NL; i++) begin
         rd_lane_i = 4'(i);
         #1;
         for (int j = 0; j < NS; j++) begin
            chk(rd_map_o[j] == exp_pass(i, j, alt_dut, alt_tx), tag,
                64'(rd_map_o[j]), 64'(exp_pass(i, j, alt_dut, alt_tx)));
         end
      end
      @(negedge clk);
      chk(done_o && !busy_o && !step_valid_o, "R8 done holds", 64'(done_o), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !done_o && !step_valid_o, "R1 reset flags",
          {61'd0, busy_o, done_o, step_valid_o}, 64'd0);
      for (int i = 0; i < NL; i++) begin
         rd_lane_i = 4'(i);
         #1;
         chk(rd_map_o == '0, "R1 reset map", rd_map_o, 64'd0);
      end
      sweep(2, 1'b1, 1'b0, 1'b0, -1, "R5 scrambled map");
      sweep(0, 1'b0, 1'b0, 1'b0, -1, "R6 plain map");
      sweep(3, 1'b1, 1'b0, 1'b0, -1, "R4 dwell map");
      sweep(1, 1'b1, 1'b1, 1'b1, -1, "R7 inverted lanes map");
      sweep(1, 1'b1, 1'b1, 1'b0, -1, "R7 inversion mismatch map");
      sweep(2, 1'b0, 1'b0, 1'b0, 70, "R9 start during sweep map");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule